// File: doc/BRIEF.md
# Posted-Write Host Register File with Commit Toggle

This block is the host-facing register file of a larger device. A host write is not applied at once. The address and data go into a single holding latch, and the addressed register takes the data a fixed number of system-clock cycles later. A one-bit commit toggle inverts on every commit. The host can read the toggle and poll it for a change of state, and so learn that its last write has landed. The host must leave enough cycles between a write and the next access to the same register. A write that arrives while an earlier one is still held replaces it.

The register file has plain control registers, sticky status registers and interrupt-enable registers. Each status register has its own enable register. Hardware events set status bits. The host clears a status bit by writing a zero to it, and a one in the written data keeps that bit as it is. A single interrupt output is high while any status bit is set together with its enable bit.

With the default parameters the address map is as follows. Address 0 reads the toggle in bit 0, with the other bits zero. Addresses 1 and 2 are the control registers. Addresses 3 and 4 are the status registers. Addresses 5 and 6 are their enables, in the same order. All other addresses are unmapped.

Top module: `hostreg_posted`

## Requirements
- R1: A write accepted at clock edge E (cs and wr high) changes the addressed register at edge E+3 (COMMIT_LAT). A read sampled at edge E+3 returns the old value, and a read sampled at E+4 returns the new one.
- R2: A write accepted while an earlier write is still pending replaces the latched address and data and restarts the delay. Only the later write is committed, and the earlier one is lost.
- R3: The toggle (bit 0 at address 0, reset value 0) inverts exactly once for each commit. This holds for any address, mapped or unmapped, including address 0. Writes never change address 0 in any other way.
- R4: A 1 on a bit of hw_set (status register k uses bits k*8 to k*8+7) sets the matching status bit at that clock edge. The bit stays set until the host clears it.
- R5: A commit to a status register clears each bit where the written data has a 0 and leaves unchanged each bit where it has a 1.
- R6: When a hardware set and a host clear of the same status bit fall on the same edge, the bit ends up set.
- R7: irq is high exactly when some status bit and the enable bit at the same position in the matching enable register are both 1.
- R8: After reset all registers, the toggle, rdata and irq are 0.
- R9: rdata is loaded at an edge where cs and rd are both high, with the current value of the addressed register (0 for unmapped addresses). At other edges it holds its value.
- R10: wr and rd have no effect when cs is low.
- R11: Control and enable registers return the last value committed to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select, active high |
| wr | input | 1 | Write strobe, sampled with cs |
| rd | input | 1 | Read strobe, sampled with cs |
| addr | input | AW (4) | Register address |
| wdata | input | DW (8) | Write data |
| rdata | output | DW (8) | Registered read data |
| hw_set | input | NSTAT*DW (16) | Per-bit hardware set pulses for the status registers |
| irq | output | 1 | Interrupt, OR of status AND enable |

## Verification
The address sweep writes a distinct value to each of the 16 addresses and reads all of them back. This separates correct decode from aliasing, shows that unmapped addresses read 0, and shows that each write, even one to the toggle address, moves the toggle once. For each status register, the clear sweep uses masks with only zeros, only ones, alternating bits and single bits. This tells write-zero-to-clear apart from write-one-to-clear or a plain store. Reads placed at E+3 and E+4, a back-to-back write pair and a set pulse on the commit edge check the commit delay, the overwrite of the latch and set-over-clear priority. The interrupt walk tries every bit position with a matching enable and with a non-matching one, so that an enable mask that is wrong by one bit, or an OR taken over the wrong register, is caught.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;
   // Region of the address map that a decoded address falls into.
   typedef enum logic [2:0] {
      RG_TOG  = 3'd0,
      RG_CTRL = 3'd1,
      RG_STAT = 3'd2,
      RG_EN   = 3'd3,
      RG_NONE = 3'd4
   } region_e;

   function automatic region_e region_of(input int a, input int ctrl_base,
                                         input int stat_base, input int en_base,
                                         input int end_addr);
      if (a == 0)              return RG_TOG;
      else if (a < stat_base)  return (a >= ctrl_base) ? RG_CTRL : RG_NONE;
      else if (a < en_base)    return RG_STAT;
      else if (a < end_addr)   return RG_EN;
      else                     return RG_NONE;
   endfunction
endpackage

// File: rtl/hostreg_wlatch.sv
// Holding latch for one posted write plus the commit delay counter and the toggle.
module hostreg_wlatch #(
   parameter int AW  = 4,
   parameter int DW  = 8,
   parameter int LAT = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc,
   input  logic [AW-1:0] a_in,
   input  logic [DW-1:0] d_in,
   output logic          commit,
   output logic [AW-1:0] a_q,
   output logic [DW-1:0] d_q,
   output logic          tog
);
   localparam int CW = (LAT < 2) ? 1 : $clog2(LAT + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         d_q <= '0;
         cnt <= '0;
         tog <= 1'b0;
      end else begin
         if (acc) begin
            a_q <= a_in;
            d_q <= d_in;
            cnt <= CW'(LAT);
         end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end
         if (commit) tog <= ~tog;
      end
   end

   // The commit edge is the one at which the counter leaves 1.
   assign commit = (cnt == CW'(1));
endmodule

// File: rtl/hostreg_stat_bank.sv
// One sticky status register and its interrupt-enable register.
module hostreg_stat_bank #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] set_in,
   input  logic          stat_we,
   input  logic          en_we,
   input  logic [DW-1:0] wd,
   output logic [DW-1:0] stat,
   output logic [DW-1:0] en,
   output logic          flag
);
   logic [DW-1:0] keep;

   // Written zeros clear; written ones keep; hardware sets override both.
   assign keep = stat_we ? wd : {DW{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
         en   <= '0;
      end else begin
         stat <= (stat & keep) | set_in;
         if (en_we) en <= wd;
      end
   end

   assign flag = |(stat & en);
endmodule

// File: rtl/hostreg_rdmux.sv
// Read path: selects the addressed register according to the address map.
module hostreg_rdmux
   import hostreg_pkg::*;
#(
   parameter int AW    = 4,
   parameter int DW    = 8,
   parameter int NCTRL = 2,
   parameter int NSTAT = 2
) (
   input  logic [AW-1:0]          addr,
   input  logic                   tog,
   input  logic [NCTRL*DW-1:0]    ctrl_flat,
   input  logic [NSTAT*DW-1:0]    stat_flat,
   input  logic [NSTAT*DW-1:0]    en_flat,
   output logic [DW-1:0]          val
);
   localparam int CB = 1;
   localparam int SB = CB + NCTRL;
   localparam int EB = SB + NSTAT;
   localparam int NR = EB + NSTAT;

   region_e rg;
   int      ai;

   always_comb begin
      ai  = int'(addr);
      rg  = region_of(ai, CB, SB, EB, NR);
      val = '0;
      unique case (rg)
         RG_TOG:  val = DW'(tog);
         RG_CTRL: val = ctrl_flat[(ai - CB)*DW +: DW];
         RG_STAT: val = stat_flat[(ai - SB)*DW +: DW];
         RG_EN:   val = en_flat[(ai - EB)*DW +: DW];
         default: val = '0;
      endcase
   end
endmodule

// File: rtl/hostreg_posted.sv
module hostreg_posted #(
   parameter int AW         = 4,
   parameter int DW         = 8,
   parameter int NCTRL      = 2,
   parameter int NSTAT      = 2,
   parameter int COMMIT_LAT = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs,
   input  logic                  wr,
   input  logic                  rd,
   input  logic [AW-1:0]         addr,
   input  logic [DW-1:0]         wdata,
   output logic [DW-1:0]         rdata,
   input  logic [NSTAT*DW-1:0]   hw_set,
   output logic                  irq
);
   localparam int CB = 1;
   localparam int SB = CB + NCTRL;
   localparam int EB = SB + NSTAT;
   localparam int NR = EB + NSTAT;

   if (AW < 1 || DW < 1)      $error("hostreg_posted: AW and DW must be positive");
   if (NCTRL < 1 || NSTAT < 1) $error("hostreg_posted: need at least one control and one status register");
   if (COMMIT_LAT < 1)        $error("hostreg_posted: COMMIT_LAT must be at least 1");
   if (NR > (1 << AW))        $error("hostreg_posted: address map does not fit in AW bits");

   logic                commit_w;
   logic [AW-1:0]       c_addr;
   logic [DW-1:0]       c_data;
   logic                tog_w;
   logic [NCTRL*DW-1:0] ctrl_flat;
   logic [NSTAT*DW-1:0] stat_flat;
   logic [NSTAT*DW-1:0] en_flat;
   logic [NSTAT-1:0]    flags;
   logic [DW-1:0]       rd_val;

   hostreg_wlatch #(.AW(AW), .DW(DW), .LAT(COMMIT_LAT)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .acc    (cs & wr),
      .a_in   (addr),
      .d_in   (wdata),
      .commit (commit_w),
      .a_q    (c_addr),
      .d_q    (c_data),
      .tog    (tog_w)
   );

   // Plain control registers.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_flat <= '0;
      end else if (commit_w) begin
         for (int i = 0; i < NCTRL; i++) begin
            if (c_addr == AW'(CB + i)) ctrl_flat[i*DW +: DW] <= c_data;
         end
      end
   end

   // Status/enable pairs.
   for (genvar g = 0; g < NSTAT; g++) begin : g_stat
      logic [DW-1:0] s_q, e_q;
      hostreg_stat_bank #(.DW(DW)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_in  (hw_set[g*DW +: DW]),
         .stat_we (commit_w && (c_addr == AW'(SB + g))),
         .en_we   (commit_w && (c_addr == AW'(EB + g))),
         .wd      (c_data),
         .stat    (s_q),
         .en      (e_q),
         .flag    (flags[g])
      );
      assign stat_flat[g*DW +: DW] = s_q;
      assign en_flat[g*DW +: DW]   = e_q;
   end

   assign irq = |flags;

   hostreg_rdmux #(.AW(AW), .DW(DW), .NCTRL(NCTRL), .NSTAT(NSTAT)) u_rd (
      .addr      (addr),
      .tog       (tog_w),
      .ctrl_flat (ctrl_flat),
      .stat_flat (stat_flat),
      .en_flat   (en_flat),
      .val       (rd_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rdata <= '0;
      else if (cs && rd)  rdata <= rd_val;
   end
endmodule

// File: rtl/hostreg_posted_chk.sv
module hostreg_posted_chk #(
   parameter int DW    = 8,
   parameter int NCTRL = 2,
   parameter int NSTAT = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                irq,
   input logic [NSTAT*DW-1:0] hw_set,
   input logic                commit,
   input logic                tog,
   input logic [NCTRL*DW-1:0] ctrl_flat,
   input logic [NSTAT*DW-1:0] stat_flat
);
   logic up;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) up <= 1'b0;
      else        up <= 1'b1;
   end

   // R1: control registers move only on a commit edge.
   p_ctrl_on_commit_r1: assert property (@(posedge clk) disable iff (!rst_n || !up)
      !$stable(ctrl_flat) |-> $past(commit));

   // R2: a commit is a single-cycle event.
   p_single_commit_r2: assert property (@(posedge clk) disable iff (!rst_n || !up)
      commit |=> !commit);

   // R3: toggle inverts on each commit and holds otherwise.
   p_toggle_flip_r3: assert property (@(posedge clk) disable iff (!rst_n || !up)
      $past(commit) |-> (tog != $past(tog)));
   p_toggle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n || !up)
      !$past(commit) |-> $stable(tog));

   // R4: a status bit rises only where hardware pulsed it.
   p_stat_rise_hw_r4: assert property (@(posedge clk) disable iff (!rst_n || !up)
      (stat_flat & ~$past(stat_flat) & ~$past(hw_set)) == '0);

   // R5: a status bit falls only on a host commit.
   p_stat_fall_commit_r5: assert property (@(posedge clk) disable iff (!rst_n || !up)
      ((~stat_flat & $past(stat_flat)) != '0) |-> $past(commit));

   // R6: every pulsed bit is set afterwards, whatever the host wrote.
   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n || !up)
      (stat_flat & $past(hw_set)) == $past(hw_set));

   // R7: the interrupt rises only after a hardware event or a host commit.
   p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n || !up)
      $rose(irq) |-> ($past(commit) || ($past(hw_set) != '0)));
endmodule

bind hostreg_posted hostreg_posted_chk #(.DW(DW), .NCTRL(NCTRL), .NSTAT(NSTAT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq       (irq),
   .hw_set    (hw_set),
   .commit    (commit_w),
   .tog       (tog_w),
   .ctrl_flat (ctrl_flat),
   .stat_flat (stat_flat)
);

// File: tb/sim_hostreg_posted.sv
module sim_hostreg_posted;
   localparam int AW = 4, DW = 8, NCTRL = 2, NSTAT = 2, LAT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, wr = 1'b0, rd = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic [NSTAT*DW-1:0] hw_set = '0;
   logic irq;

   always #4 clk = ~clk;   // 125 MHz

   hostreg_posted #(.AW(AW), .DW(DW), .NCTRL(NCTRL), .NSTAT(NSTAT), .COMMIT_LAT(LAT)) u0 (
      .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
      .wdata(wdata), .rdata(rdata), .hw_set(hw_set), .irq(irq));

   int nchk = 0, nfail = 0;
   int cyc = 0, last_acc = -100;
   always @(posedge clk) cyc <= cyc + 1;

   // Bench model of the register contents.
   logic [DW-1:0] ctrl_m [NCTRL];
   logic [DW-1:0] stat_m [NSTAT];
   logic [DW-1:0] en_m   [NSTAT];
   logic          tog_m;
   logic [DW-1:0] got;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] exp_rd(input int a);
      if (a == 0) return DW'(tog_m);
      if (a >= 1 && a <= 2) return ctrl_m[a-1];
      if (a >= 3 && a <= 4) return stat_m[a-3];
      if (a >= 5 && a <= 6) return en_m[a-5];
      return '0;
   endfunction

   function automatic void model_commit(input int a, input logic [DW-1:0] d);
      tog_m = ~tog_m;
      if (a >= 1 && a <= 2) ctrl_m[a-1] = d;
      else if (a >= 3 && a <= 4) stat_m[a-3] = stat_m[a-3] & d;
      else if (a >= 5 && a <= 6) en_m[a-5] = d;
   endfunction

   task automatic wr_raw(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      cs = 1'b1; wr = 1'b1; addr = AW'(a); wdata = d;
      @(posedge clk);
      last_acc = cyc;
      #1; cs = 1'b0; wr = 1'b0;
   endtask

   // Spaced write: checks host spacing, waits for the commit, updates the model.
   task automatic wr_ok(input int a, input logic [DW-1:0] d);
      check("R2 host spacing", 32'(((cyc + 1 - last_acc) > LAT) ? 1 : 0), 32'd1);
      wr_raw(a, d);
      repeat (LAT + 1) @(posedge clk);
      #1;
      model_commit(a, d);
   endtask

   task automatic rd_now(input int a, output logic [DW-1:0] v);
      @(negedge clk);
      cs = 1'b1; rd = 1'b1; addr = AW'(a);
      @(posedge clk);
      #1; v = rdata; cs = 1'b0; rd = 1'b0;
   endtask

   task automatic pulse(input int s, input logic [DW-1:0] p);
      @(negedge clk);
      hw_set = '0;
      hw_set[s*DW +: DW] = p;
      @(posedge clk);
      #1; hw_set = '0;
      stat_m[s] = stat_m[s] | p;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      for (int i = 0; i < NCTRL; i++) ctrl_m[i] = '0;
      for (int i = 0; i < NSTAT; i++) begin stat_m[i] = '0; en_m[i] = '0; end
      tog_m = 1'b0;
      repeat (3) @(posedge clk);
      #1; rst_n = 1'b1;

      // R8: reset state
      check("R8 irq after reset", 32'(irq), 32'd0);
      check("R8 rdata after reset", 32'(rdata), 32'd0);
      for (int a = 0; a < 16; a++) begin
         rd_now(a, got);
         check($sformatf("R8 reset value addr %0d", a), 32'(got), 32'd0);
      end

      // R1: commit delay on a control register and on the toggle
      wr_raw(1, 8'h6C);
      repeat (2) @(negedge clk);
      rd_now(1, got);
      check("R1 read at E+3 old", 32'(got), 32'h00);
      rd_now(1, got);
      check("R1 read at E+4 new", 32'(got), 32'h6C);
      model_commit(1, 8'h6C);
      rd_now(0, got);
      check("R3 toggle after first commit", 32'(got), 32'(exp_rd(0)));

      // R3/R11/R9: sweep every address, then read all back
      for (int a = 0; a < 16; a++) wr_ok(a, DW'((a * 37 + 5) & 8'hFF));
      for (int a = 0; a < 16; a++) begin
         rd_now(a, got);
         check($sformatf("R11 R9 sweep addr %0d", a), 32'(got), 32'(exp_rd(a)));
      end

      // R9: rdata holds without a read strobe
      rd_now(2, got);
      wr_ok(2, 8'hE1);
      repeat (2) @(posedge clk);
      #1;
      check("R9 rdata holds", 32'(rdata), 32'(got));

      // R10: strobes ignored with cs low
      @(negedge clk);
      cs = 1'b0; wr = 1'b1; rd = 1'b1; addr = 4'd1; wdata = 8'h99;
      @(posedge clk); #1; wr = 1'b0; rd = 1'b0;
      check("R10 rdata unchanged by rd without cs", 32'(rdata), 32'(got));
      repeat (LAT + 1) @(posedge clk);
      rd_now(1, got);
      check("R10 ctrl unchanged by wr without cs", 32'(got), 32'(exp_rd(1)));
      rd_now(0, got);
      check("R10 toggle unchanged", 32'(got), 32'(exp_rd(0)));

      // R2: back-to-back writes, the first is lost
      wr_raw(1, 8'h11);
      wr_raw(2, 8'h22);
      repeat (LAT + 1) @(posedge clk);
      model_commit(2, 8'h22);
      rd_now(1, got);
      check("R2 first write lost", 32'(got), 32'(exp_rd(1)));
      rd_now(2, got);
      check("R2 second write landed", 32'(got), 32'h22);
      rd_now(0, got);
      check("R2 R3 single toggle", 32'(got), 32'(exp_rd(0)));

      // R4/R5: sticky set and write-zero-to-clear sweep
      for (int s = 0; s < NSTAT; s++) begin
         for (int k = 0; k < 8; k++) begin
            logic [DW-1:0] m;
            case (k)
               0: m = 8'h00; 1: m = 8'hFF; 2: m = 8'hA5; 3: m = 8'h5A;
               4: m = 8'h01; 5: m = 8'h80; 6: m = 8'h3C; default: m = 8'hC3;
            endcase
            pulse(s, 8'hFF);
            rd_now(3 + s, got);
            check($sformatf("R4 set stat%0d", s), 32'(got), 32'hFF);
            repeat (2) @(posedge clk);
            rd_now(3 + s, got);
            check($sformatf("R4 sticky stat%0d", s), 32'(got), 32'hFF);
            wr_ok(3 + s, m);
            rd_now(3 + s, got);
            check($sformatf("R5 clear stat%0d mask %h", s, m), 32'(got), 32'(m));
         end
      end

      // R6: set and clear on the same edge
      pulse(0, 8'hFF);
      wr_raw(3, 8'h00);
      repeat (2) @(negedge clk);
      pulse(0, 8'h10);
      repeat (2) @(posedge clk);
      stat_m[0] = 8'h10;
      tog_m = ~tog_m;
      rd_now(3, got);
      check("R6 set wins over clear", 32'(got), 32'h10);

      // R7: interrupt walk over every bit
      for (int s = 0; s < NSTAT; s++) begin
         wr_ok(3, 8'h00); wr_ok(4, 8'h00);
         wr_ok(5, 8'h00); wr_ok(6, 8'h00);
         for (int b = 0; b < DW; b++) begin
            wr_ok(5 + s, DW'(1) << b);
            pulse(s, DW'(1) << ((b + 1) % DW));
            check($sformatf("R7 other bit s%0d b%0d", s, b), 32'(irq), 32'd0);
            pulse(1 - s, DW'(1) << b);
            check($sformatf("R7 other reg s%0d b%0d", s, b), 32'(irq), 32'd0);
            pulse(s, DW'(1) << b);
            check($sformatf("R7 match s%0d b%0d", s, b), 32'(irq), 32'd1);
            wr_ok(5 + s, 8'h00);
            check($sformatf("R7 enable off s%0d b%0d", s, b), 32'(irq), 32'd0);
            wr_ok(3 + s, 8'h00);
            wr_ok(4 - s, 8'h00);
         end
      end
      rd_now(0, got);
      check("R3 toggle after walk", 32'(got), 32'(exp_rd(0)));

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule